// File: doc/BRIEF.md
# Two-Way Cache Lookup with Overlapped Address Translation

This block is a read-only, two-way set-associative data cache that starts its set read as soon as a virtual address arrives. The set index and the word position are both taken from the low twelve address bits, which stay the same under translation. So the tag and data read for a set happens during the same cycle in which the translation buffer turns the upper virtual bits into a physical page number.

In the cycle after a request is accepted, the translation result arrives on `tlb_hit` and `tlb_ptag`. Each way compares its stored physical page number with `tlb_ptag`. The block then reports hit or miss and, on a hit, returns the selected 32-bit word. When a lookup misses but translation succeeded, the block asks an external memory for the whole 16-byte line at the physical address. It writes the line into a victim way and drops the request; the requester then retries. When translation fails, the block does nothing and waits for a retry.

Top module: `vipt_cache`

## Requirements
- R1: Reset marks every line in both ways invalid, so the first lookup of any set after reset misses.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. The set is `req_vaddr[11:4]` and the word within the line is `req_vaddr[3:2]`. Bits 31..12 of `req_vaddr` play no part in the lookup. The response (`rsp_valid`) appears in the cycle after acceptance, and `tlb_hit`/`tlb_ptag` are sampled in that same cycle.
- R3: `rsp_hit` is high only when `tlb_hit` is high and a valid way of the set holds a stored 18-bit tag equal to `tlb_ptag` in all bits. On a hit, `rsp_data` is the selected word of the matching way.
- R4: A response with `tlb_hit` low reports no hit, starts no line fill and leaves the contents of the cache unchanged.
- R5: A response with `tlb_hit` high and no tag match raises `fill_req` in the next cycle with `fill_paddr = {tlb_ptag, set, 4'b0000}`. Both are held until the cycle in which `fill_valid` is high, and that cycle ends the fill.
- R6: Word k of a line is carried in `fill_data[32k+31:32k]`. After the fill completes, a lookup of word k returns that slice.
- R7: Two lines with different tags that map to the same set can be resident at once, one in each way, and both hit.
- R8: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid. Otherwise the victim is the way not most recently used. A hit or a fill marks its way as most recently used for that set.
- R9: `req_ready` is low from the response cycle that triggers a fill until the cycle after `fill_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| tlb_hit | input | 1 | Translation succeeded (response cycle) |
| tlb_ptag | input | 18 | Physical page number (response cycle) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Selected word, zero when no hit |
| fill_req | output | 1 | Line fill request |
| fill_paddr | output | 30 | Line-aligned physical address of the fill |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 128 | Whole line, word 0 in the low bits |

## Verification
The assertions assume that the translation inputs are meaningful only in a response cycle. They also assume that `fill_valid` is raised only while `fill_req` is high, and that no two ways of a set ever hold the same tag, which holds as long as fills follow misses only. The bench keeps to these assumptions. It drives `tlb_hit` and `tlb_ptag` only in the cycle after a request, answers each fill only after it has seen `fill_req`, and issues requests only when `req_ready` is high. It sweeps every set with tags and upper address bits computed from the set number.

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 30,
  parameter int PAGE_W = 12,
  parameter int LINE_B = 16,
  parameter int SETS   = 256,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     tlb_hit,
  input  logic [PA_W-PAGE_W-1:0]   tlb_ptag,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [WORD_W-1:0]        rsp_data,
  output logic                     fill_req,
  output logic [PA_W-1:0]          fill_paddr,
  input  logic                     fill_valid,
  input  logic [LINE_B*8-1:0]      fill_data
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = PA_W - PAGE_W;
  localparam int LINE_W = LINE_B * 8;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;

  logic [TAG_W-1:0]  tag_q [2][SETS];
  logic [LINE_W-1:0] dat_q [2][SETS];
  logic [SETS-1:0]   vld_q [2];
  logic [SETS-1:0]   lru_q;

  logic              s_vld;
  logic [IDX_W-1:0]  s_idx;
  logic [WSEL_W-1:0] s_wsel;
  logic [TAG_W-1:0]  rd_tag [2];
  logic [LINE_W-1:0] rd_dat [2];
  logic [1:0]        rd_vld;

  logic              busy_q;
  logic              f_way;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;

  logic [1:0]        hw;
  logic              acc, any_hit, start_fill, victim;
  logic [IDX_W-1:0]  a_idx;

  assign a_idx      = req_vaddr[OFF_W +: IDX_W];
  assign hw[0]      = rd_vld[0] && (rd_tag[0] == tlb_ptag);
  assign hw[1]      = rd_vld[1] && (rd_tag[1] == tlb_ptag);
  assign any_hit    = s_vld && tlb_hit && (hw != 2'b00);
  assign start_fill = s_vld && tlb_hit && (hw == 2'b00);
  assign victim     = !rd_vld[0] ? 1'b0 : !rd_vld[1] ? 1'b1 : !lru_q[s_idx];
  assign req_ready  = !busy_q && !start_fill;
  assign acc        = req_valid && req_ready;

  assign rsp_valid  = s_vld;
  assign rsp_hit    = any_hit;
  assign rsp_data   = !any_hit ? '0 :
                      hw[1] ? rd_dat[1][s_wsel*WORD_W +: WORD_W]
                            : rd_dat[0][s_wsel*WORD_W +: WORD_W];
  assign fill_req   = busy_q;
  assign fill_paddr = {f_tag, f_idx, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_vld    <= 1'b0;
      busy_q   <= 1'b0;
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      s_vld <= acc;
      if (any_hit) lru_q[s_idx] <= hw[1];
      if (start_fill) busy_q <= 1'b1;
      if (busy_q && fill_valid) begin
        busy_q              <= 1'b0;
        vld_q[f_way][f_idx] <= 1'b1;
        lru_q[f_idx]        <= f_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s_idx  <= a_idx;
      s_wsel <= req_vaddr[BYTE_W +: WSEL_W];
      for (int w = 0; w < 2; w++) begin
        rd_tag[w] <= tag_q[w][a_idx];
        rd_dat[w] <= dat_q[w][a_idx];
        rd_vld[w] <= vld_q[w][a_idx];
      end
    end
    if (start_fill) begin
      f_way <= victim;
      f_idx <= s_idx;
      f_tag <= tlb_ptag;
    end
    if (busy_q && fill_valid) begin
      tag_q[f_way][f_idx] <= f_tag;
      dat_q[f_way][f_idx] <= fill_data;
    end
  end

  p_hit_needs_tlb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (tlb_hit && rsp_valid));

  p_tlbmiss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !tlb_hit && !fill_req) |=> !fill_req);

  p_fill_after_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && tlb_hit && !rsp_hit) |=>
      (fill_req && fill_paddr[PA_W-1:PAGE_W] == $past(tlb_ptag)));

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_paddr)));

  p_one_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(hw));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);
endmodule

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_vaddr = '0;
  logic         tlb_hit = 1'b0;
  logic [17:0]  tlb_ptag = '0;
  logic         rsp_valid, rsp_hit;
  logic [31:0]  rsp_data;
  logic         fill_req;
  logic [29:0]  fill_paddr;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [17:0] mtag [2][256];
  bit          mval [2][256];
  bit          mlru [256];

  always #2 clk = ~clk;

  vipt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tlb_hit(tlb_hit), .tlb_ptag(tlb_ptag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_paddr(fill_paddr),
    .fill_valid(fill_valid), .fill_data(fill_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wordval(input logic [17:0] pt, input logic [7:0] idx, input int k);
    return {pt[13:0], idx, k[1:0], 8'hA5};
  endfunction

  function automatic logic [17:0] tag_a(input int idx);
    return {2'b01, 8'(idx * 37), 8'(idx)};
  endfunction

  task automatic access(input logic [19:0] hi, input int idx, input int w,
                        input logic [17:0] pt, input bit th, input string req);
    bit exp_hit;
    bit hway;
    bit vic;
    exp_hit = 0;
    hway = 0;
    for (int v = 0; v < 2; v++)
      if (th && mval[v][idx] && mtag[v][idx] == pt) begin exp_hit = 1; hway = v[0]; end
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready before request", 64'(req_ready), 1);
    req_valid = 1'b1;
    req_vaddr = {hi, 8'(idx), 2'(w), 2'b00};
    @(negedge clk);
    req_valid = 1'b0;
    tlb_hit = th;
    tlb_ptag = pt;
    #0.5;
    chk(rsp_valid === 1'b1, "R2 response one cycle after accept", 64'(rsp_valid), 1);
    chk(rsp_hit === exp_hit, req, 64'(rsp_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk(rsp_data === wordval(pt, 8'(idx), w), "R6 word data", 64'(rsp_data), 64'(wordval(pt, 8'(idx), w)));
      mlru[idx] = hway;
    end
    if (th && !exp_hit)
      chk(req_ready === 1'b0, "R9 ready low on miss", 64'(req_ready), 0);
    @(negedge clk);
    tlb_hit = 1'b0;
    if (th && !exp_hit) begin
      chk(fill_req === 1'b1 && fill_paddr === {pt, 8'(idx), 4'h0}, "R5 fill request address",
          64'({fill_req, fill_paddr}), 64'({1'b1, pt, 8'(idx), 4'h0}));
      @(negedge clk);
      chk(fill_req === 1'b1 && req_ready === 1'b0, "R5 R9 fill held", 64'({fill_req, req_ready}), 64'b10);
      fill_valid = 1'b1;
      for (int k = 0; k < 4; k++) fill_data[32*k +: 32] = wordval(pt, 8'(idx), k);
      @(negedge clk);
      fill_valid = 1'b0;
      chk(fill_req === 1'b0, "R5 fill ends", 64'(fill_req), 0);
      vic = !mval[0][idx] ? 1'b0 : !mval[1][idx] ? 1'b1 : !mlru[idx];
      mval[vic][idx] = 1;
      mtag[vic][idx] = pt;
      mlru[idx] = vic;
    end else begin
      chk(fill_req === 1'b0, th ? "R3 no fill on hit" : "R4 no fill on translation miss", 64'(fill_req), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 2; v++) for (int s = 0; s < 256; s++) begin mval[v][s] = 0; mtag[v][s] = '0; end
    for (int s = 0; s < 256; s++) mlru[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(req_ready === 1'b1 && fill_req === 1'b0 && rsp_valid === 1'b0, "R1 reset outputs",
        64'({req_ready, fill_req, rsp_valid}), 64'b100);

    // R1 R5 R6: cold misses fill every set
    for (int s = 0; s < 256; s++)
      access(20'(s * 4099), s, s % 4, tag_a(s), 1'b1, "R1 cold lookup misses");

    // R2 R3 R6: every word of every set hits, upper virtual bits varied
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++)
        access(20'(s * 77 + w * 9001), s, w, tag_a(s), 1'b1, "R2 R3 hit with matching tag");

    foreach (mlru[s]) begin end
    for (int t = 0; t < 3; t++) begin
      int s;
      logic [17:0] tb_, tc_;
      s = (t == 0) ? 0 : (t == 1) ? 255 : 77;
      tb_ = tag_a(s) ^ 18'h20000;
      tc_ = tag_a(s) ^ 18'h00100;
      access(20'h12345, s, 1, tag_a(s), 1'b0, "R4 translation miss reports no hit");
      access(20'h0, s, 1, tag_a(s), 1'b1, "R4 contents kept after translation miss");
      access(20'h1, s, 2, tb_, 1'b1, "R3 one-bit tag difference misses");
      access(20'h2, s, 2, tb_, 1'b1, "R7 second way hits");
      access(20'h3, s, 3, tag_a(s), 1'b1, "R7 first way still hits");
      access(20'h4, s, 0, tc_, 1'b1, "R8 third tag misses");
      access(20'h5, s, 0, tag_a(s), 1'b1, "R8 most recent line kept");
      access(20'h6, s, 0, tb_, 1'b1, "R8 least recent line evicted");
      access(20'h7, s, 0, tc_, 1'b1, "R8 replacement order");
      access(20'h8, s, 3, tb_, 1'b0, "R4 translation miss with resident tag");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule